// File: doc/BRIEF.md
# Watchpoint Match and Chaining Unit

This block watches every processor access and decides whether it should stop the core. Eight programmable matchpoints compare the access value against their own reference values. Each matchpoint has a selectable condition and a choice of signed or unsigned arithmetic, and each looks only at the access kinds it is set up for. The matchpoint results feed eleven watchpoints. Each watchpoint can stand alone, or be ANDed or ORed with the watchpoint before it, so conditions can be built up along the chain. Watchpoints 8 and 9 fire when a counter equals its match value. Watchpoint 10 follows an external input.

Every watchpoint that fires can add one to one of two counters and can request a break. A single-step mode raises a break on every instruction fetch. The register bank that holds the control, value, mode and counter registers is outside this block. The bank feeds them in, and takes the registered next counter values back.

All outputs are registered. The result for an access presented before a clock edge is visible after that edge.

Top module: `wp_chain_unit`

## Requirements
- R1: A matchpoint can hit only when its present bit (control bit 0) is 1 and its compare-type field (control bits 7:5) matches the access kind.
  - Access kinds on `acc_kind_i`: 1 is fetch, 2 is load address, 3 is store address, 4 is load data, 5 is store data.
  - Compare types: 1 is fetch, 2 is load address, 3 is store address, 4 is load data, 5 is store data, 6 is load or store address, 7 is load or store data. Type 0 never hits.
- R2: Condition field (control bits 3:1): 1 is equal, 2 is not equal, 3 is access less than reference, 4 is less or equal, 5 is greater, 6 is greater or equal. With control bit 4 at 0, the comparison is unsigned.
- R3: With control bit 4 at 1, the ordered conditions treat both operands as two's-complement signed values.
- R4: Condition 0 hits when the AND of the access value and the reference value is non-zero. Condition 7 never hits.
- R5: Each watchpoint has a 2-bit mode in `chain_mode_i[2i+1:2i]`. Mode 0 uses the watchpoint's own event, mode 1 ANDs it with watchpoint i-1, mode 2 ORs it with watchpoint i-1, and mode 3 never fires.
- R6: Watchpoint 0 has no predecessor, so in every mode other than 3 it equals matchpoint 0.
- R7: The own event of watchpoint 8 is counter 0 equal to match value 0. Watchpoint 9 does the same with counter 1. The own event of watchpoint 10 is `ext_wp_i`.
- R8: Each firing watchpoint adds one to the counter picked by its `cnt_sel_i` bit (0 picks counter 0) when that counter's enable bit is set. The result appears on `cnt_next_o` modulo 2^CW, and a counter with no increments passes through unchanged.
- R9: `brk_o` rises when any firing watchpoint has its `brk_en_i` bit set.
- R10: With `single_step_i` high, every fetch access raises `brk_o`, whether or not any watchpoint fires.
- R11: While `enable_i` is low or `cpu_rst_i` is high, no watchpoint fires, no break is raised and no counter is incremented.
- R12: Access kind 0 means no access: no hit, no break, no increment. Reset clears every output to 0, and results appear one clock after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Unit enable |
| cpu_rst_i | input | 1 | Processor held in reset |
| single_step_i | input | 1 | Break on every fetch |
| acc_kind_i | input | 3 | Access kind of this cycle |
| acc_value_i | input | DW | Access address or data |
| mp_ctrl_i | input | 8*N_MP | Matchpoint control words |
| mp_value_i | input | DW*N_MP | Matchpoint reference values |
| chain_mode_i | input | 2*(N_MP+3) | Chain mode per watchpoint |
| cnt_sel_i | input | N_MP+3 | Counter select per watchpoint |
| brk_en_i | input | N_MP+3 | Break enable per watchpoint |
| cnt_en_i | input | 2 | Counter enables |
| cnt_i | input | 2*CW | Current counter values |
| cnt_match_i | input | 2*CW | Counter match values |
| ext_wp_i | input | 1 | External watchpoint event |
| wp_hit_o | output | N_MP+3 | Registered watchpoint hit vector |
| brk_o | output | 1 | Registered breakpoint request |
| cnt_next_o | output | 2*CW | Registered updated counter values |

## Verification
The hardest situation to reach from the ports is a long chain. In it, an OR propagates through several watchpoints, or a counter-equal event at watchpoint 8 combines with the data-driven chain below it. The bench reaches this by clearing every matchpoint except the ones under test. It also parks the counter match values away from the counter values, so that counter events appear only when they are set up on purpose. It then steps the modes of neighbouring watchpoints one at a time. Counter updates are checked with several watchpoints firing into the same counter in one cycle, and at the wrap from all ones to zero.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int MP_CTRL_W = 8;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0, ACC_IFETCH = 3'd1, ACC_LD_ADDR = 3'd2,
    ACC_ST_ADDR = 3'd3, ACC_LD_DATA = 3'd4, ACC_ST_DATA = 3'd5
  } acc_kind_e;

  typedef enum logic [2:0] {
    CT_OFF = 3'd0, CT_IFETCH = 3'd1, CT_LD_ADDR = 3'd2, CT_ST_ADDR = 3'd3,
    CT_LD_DATA = 3'd4, CT_ST_DATA = 3'd5, CT_LS_ADDR = 3'd6, CT_LS_DATA = 3'd7
  } cmp_type_e;

  typedef enum logic [2:0] {
    CC_MASK = 3'd0, CC_EQ = 3'd1, CC_NE = 3'd2, CC_LT = 3'd3,
    CC_LE = 3'd4, CC_GT = 3'd5, CC_GE = 3'd6, CC_NONE = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    CH_OWN = 2'd0, CH_AND = 2'd1, CH_OR = 2'd2, CH_RSVD = 2'd3
  } chain_e;

  typedef struct packed {
    cmp_type_e ctype;   // [7:5]
    logic      sgn;     // [4]
    cond_e     cond;    // [3:1]
    logic      present; // [0]
  } mp_ctrl_t;

  function automatic logic kind_sel(cmp_type_e ct, acc_kind_e k);
    unique case (ct)
      CT_IFETCH:  return k == ACC_IFETCH;
      CT_LD_ADDR: return k == ACC_LD_ADDR;
      CT_ST_ADDR: return k == ACC_ST_ADDR;
      CT_LD_DATA: return k == ACC_LD_DATA;
      CT_ST_DATA: return k == ACC_ST_DATA;
      CT_LS_ADDR: return (k == ACC_LD_ADDR) || (k == ACC_ST_ADDR);
      CT_LS_DATA: return (k == ACC_LD_DATA) || (k == ACC_ST_DATA);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic chain_combine(chain_e m, logic own, logic prev);
    unique case (m)
      CH_OWN:  return own;
      CH_AND:  return own & prev;
      CH_OR:   return own | prev;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wpc_matchpoint.sv
module wpc_matchpoint
  import wpc_pkg::*;
#(
  parameter int DW = 32
) (
  input  mp_ctrl_t        ctrl_i,
  input  logic [DW-1:0]   ref_i,
  input  acc_kind_e       kind_i,
  input  logic [DW-1:0]   acc_i,
  output logic            hit_o
);
  logic [DW-1:0] a_x, b_x;
  logic          eq, lt, cond_hit;

  // flipping the sign bit turns a signed order into an unsigned one
  assign a_x = {acc_i[DW-1] ^ ctrl_i.sgn, acc_i[DW-2:0]};
  assign b_x = {ref_i[DW-1] ^ ctrl_i.sgn, ref_i[DW-2:0]};
  assign eq  = acc_i == ref_i;
  assign lt  = a_x < b_x;

  always_comb begin
    unique case (ctrl_i.cond)
      CC_MASK: cond_hit = |(acc_i & ref_i);
      CC_EQ:   cond_hit = eq;
      CC_NE:   cond_hit = !eq;
      CC_LT:   cond_hit = lt;
      CC_LE:   cond_hit = lt | eq;
      CC_GT:   cond_hit = !(lt | eq);
      CC_GE:   cond_hit = !lt;
      default: cond_hit = 1'b0;
    endcase
  end

  assign hit_o = ctrl_i.present & kind_sel(ctrl_i.ctype, kind_i) & cond_hit;
endmodule

// File: rtl/wpc_chain.sv
module wpc_chain
  import wpc_pkg::*;
#(
  parameter int N_MP = 8,
  localparam int N_WP = N_MP + 3
) (
  input  logic [N_MP-1:0]   mp_hit_i,
  input  logic [1:0]        cnt_eq_i,
  input  logic              ext_i,
  input  logic [2*N_WP-1:0] mode_i,
  output logic [N_WP-1:0]   hit_o
);
  for (genvar i = 0; i < N_WP; i++) begin : g_wp
    logic own, prev, res;
    if (i < N_MP) begin : g_mp
      assign own = mp_hit_i[i];
    end else if (i < N_MP + 2) begin : g_cnt
      assign own = cnt_eq_i[i-N_MP];
    end else begin : g_ext
      assign own = ext_i;
    end
    if (i == 0) begin : g_first
      assign prev = own;
    end else begin : g_next
      assign prev = g_wp[i-1].res;
    end
    assign res      = chain_combine(chain_e'(mode_i[2*i+:2]), own, prev);
    assign hit_o[i] = res;
  end
endmodule

// File: rtl/wpc_count.sv
module wpc_count #(
  parameter int N_WP = 11,
  parameter int CW   = 16,
  localparam int IW  = $clog2(N_WP + 1)
) (
  input  logic [N_WP-1:0] hit_i,
  input  logic [N_WP-1:0] sel_i,
  input  logic [1:0]      en_i,
  input  logic [2*CW-1:0] cnt_i,
  output logic [2*CW-1:0] cnt_next_o
);
  logic [IW-1:0] inc [2];

  always_comb begin
    inc[0] = '0;
    inc[1] = '0;
    for (int i = 0; i < N_WP; i++) begin
      if (hit_i[i]) begin
        if (sel_i[i]) inc[1] = inc[1] + IW'(en_i[1]);
        else          inc[0] = inc[0] + IW'(en_i[0]);
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    assign cnt_next_o[k*CW+:CW] = cnt_i[k*CW+:CW] + CW'(inc[k]);
  end
endmodule

// File: rtl/wp_chain_unit.sv
module wp_chain_unit
  import wpc_pkg::*;
#(
  parameter int N_MP = 8,
  parameter int DW   = 32,
  parameter int CW   = 16,
  localparam int N_WP = N_MP + 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enable_i,
  input  logic                   cpu_rst_i,
  input  logic                   single_step_i,
  input  logic [2:0]             acc_kind_i,
  input  logic [DW-1:0]          acc_value_i,
  input  logic [MP_CTRL_W*N_MP-1:0] mp_ctrl_i,
  input  logic [DW*N_MP-1:0]     mp_value_i,
  input  logic [2*N_WP-1:0]      chain_mode_i,
  input  logic [N_WP-1:0]        cnt_sel_i,
  input  logic [N_WP-1:0]        brk_en_i,
  input  logic [1:0]             cnt_en_i,
  input  logic [2*CW-1:0]        cnt_i,
  input  logic [2*CW-1:0]        cnt_match_i,
  input  logic                   ext_wp_i,
  output logic [N_WP-1:0]        wp_hit_o,
  output logic                   brk_o,
  output logic [2*CW-1:0]        cnt_next_o
);
  acc_kind_e         kind;
  logic [N_MP-1:0]   mp_hit;
  logic [1:0]        cnt_eq;
  logic [N_WP-1:0]   chain_hit, hit_c;
  logic [2*CW-1:0]   cnt_next_c;
  logic              active, brk_c;

  assign kind   = acc_kind_e'(acc_kind_i);
  assign active = enable_i & ~cpu_rst_i & (kind != ACC_NONE);

  for (genvar m = 0; m < N_MP; m++) begin : g_mp
    wpc_matchpoint #(.DW(DW)) u_mp (
      .ctrl_i (mp_ctrl_t'(mp_ctrl_i[m*MP_CTRL_W+:MP_CTRL_W])),
      .ref_i  (mp_value_i[m*DW+:DW]),
      .kind_i (kind),
      .acc_i  (acc_value_i),
      .hit_o  (mp_hit[m])
    );
  end

  for (genvar k = 0; k < 2; k++) begin : g_eq
    assign cnt_eq[k] = cnt_i[k*CW+:CW] == cnt_match_i[k*CW+:CW];
  end

  wpc_chain #(.N_MP(N_MP)) u_chain (
    .mp_hit_i (mp_hit),
    .cnt_eq_i (cnt_eq),
    .ext_i    (ext_wp_i),
    .mode_i   (chain_mode_i),
    .hit_o    (chain_hit)
  );

  assign hit_c = active ? chain_hit : '0;
  assign brk_c = active & ((|(hit_c & brk_en_i)) |
                           (single_step_i & (kind == ACC_IFETCH)));

  wpc_count #(.N_WP(N_WP), .CW(CW)) u_count (
    .hit_i      (hit_c),
    .sel_i      (cnt_sel_i),
    .en_i       (cnt_en_i),
    .cnt_i      (cnt_i),
    .cnt_next_o (cnt_next_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_hit_o   <= '0;
      brk_o      <= 1'b0;
      cnt_next_o <= '0;
    end else begin
      wp_hit_o   <= hit_c;
      brk_o      <= brk_c;
      cnt_next_o <= cnt_next_c;
    end
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int N_MP = 8,
  parameter int CW   = 16,
  localparam int N_WP = N_MP + 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              cpu_rst_i,
  input logic              single_step_i,
  input logic [2:0]        acc_kind_i,
  input logic [2*N_WP-1:0] chain_mode_i,
  input logic [N_WP-1:0]   brk_en_i,
  input logic [1:0]        cnt_en_i,
  input logic [2*CW-1:0]   cnt_i,
  input logic              ext_wp_i,
  input logic [N_WP-1:0]   wp_hit_o,
  input logic              brk_o,
  input logic [2*CW-1:0]   cnt_next_o
);
  logic act;
  assign act = enable_i && !cpu_rst_i && (acc_kind_i != 3'd0);

  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || cpu_rst_i) |=> (wp_hit_o == '0) && !brk_o);

  a_r12_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_kind_i == 3'd0) |=> (wp_hit_o == '0) && !brk_o);

  a_r10_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && single_step_i && acc_kind_i == 3'd1) |=> brk_o);

  a_r9_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wp_hit_o & $past(brk_en_i)) != '0) |-> brk_o);

  a_r8_hold0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i[0] |=> cnt_next_o[CW-1:0] == $past(cnt_i[CW-1:0]));

  a_r8_hold1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i[1] |=> cnt_next_o[2*CW-1:CW] == $past(cnt_i[2*CW-1:CW]));

  a_r7_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && chain_mode_i[2*N_WP-1-:2] == 2'd0) |=> wp_hit_o[N_WP-1] == $past(ext_wp_i));
endmodule

bind wp_chain_unit wpc_checker #(.N_MP(N_MP), .CW(CW)) u_wpc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .cpu_rst_i     (cpu_rst_i),
  .single_step_i (single_step_i),
  .acc_kind_i    (acc_kind_i),
  .chain_mode_i  (chain_mode_i),
  .brk_en_i      (brk_en_i),
  .cnt_en_i      (cnt_en_i),
  .cnt_i         (cnt_i),
  .ext_wp_i      (ext_wp_i),
  .wp_hit_o      (wp_hit_o),
  .brk_o         (brk_o),
  .cnt_next_o    (cnt_next_o)
);

// File: tb/wp_chain_unit_bench.sv
`timescale 1ns/1ps
module wp_chain_unit_bench;
  localparam int N_MP = 8;
  localparam int DW   = 32;
  localparam int CW   = 16;
  localparam int N_WP = N_MP + 3;
  localparam int NV   = 27;

  function automatic logic [7:0] mk(int ct, int sg, int cc, int p);
    return {ct[2:0], sg[0], cc[2:0], p[0]};
  endfunction

  // {ctrl, ref, kind, access, expected hit of watchpoint 0}
  localparam logic [75:0] VEC [NV] = '{
    {mk(1,0,1,1), 32'h100, 3'd1, 32'h100, 1'b1},        // R1 R2 eq fetch
    {mk(1,0,1,1), 32'h100, 3'd2, 32'h100, 1'b0},        // R1 wrong kind
    {mk(1,0,1,0), 32'h100, 3'd1, 32'h100, 1'b0},        // R1 not present
    {mk(0,0,1,1), 32'h100, 3'd1, 32'h100, 1'b0},        // R1 type off
    {mk(6,0,1,1), 32'h20,  3'd3, 32'h20,  1'b1},        // R1 ld/st addr
    {mk(6,0,1,1), 32'h20,  3'd2, 32'h20,  1'b1},
    {mk(6,0,1,1), 32'h20,  3'd4, 32'h20,  1'b0},
    {mk(7,0,1,1), 32'h5,   3'd5, 32'h5,   1'b1},
    {mk(4,0,1,1), 32'h5,   3'd4, 32'h5,   1'b1},
    {mk(5,0,1,1), 32'h5,   3'd4, 32'h5,   1'b0},
    {mk(2,0,2,1), 32'h5,   3'd2, 32'h6,   1'b1},        // R2 ne
    {mk(2,0,2,1), 32'h5,   3'd2, 32'h5,   1'b0},
    {mk(2,0,3,1), 32'h5,   3'd2, 32'h4,   1'b1},        // R2 lt
    {mk(2,0,3,1), 32'h5,   3'd2, 32'h5,   1'b0},
    {mk(2,0,4,1), 32'h5,   3'd2, 32'h5,   1'b1},        // R2 le
    {mk(2,0,5,1), 32'h5,   3'd2, 32'h5,   1'b0},        // R2 gt
    {mk(2,0,5,1), 32'h5,   3'd2, 32'h6,   1'b1},
    {mk(2,0,6,1), 32'h5,   3'd2, 32'h5,   1'b1},        // R2 ge
    {mk(2,0,6,1), 32'h5,   3'd2, 32'h4,   1'b0},
    {mk(2,0,3,1), 32'h5,   3'd2, 32'hFFFF_FFFF, 1'b0},  // R2 unsigned lt
    {mk(2,1,3,1), 32'h5,   3'd2, 32'hFFFF_FFFF, 1'b1},  // R3 signed lt
    {mk(2,1,5,1), 32'hFFFF_FFF0, 3'd2, 32'hFFFF_FFFF, 1'b1}, // R3 signed gt
    {mk(2,0,6,1), 32'hFFFF_FFF0, 3'd2, 32'h1, 1'b0},    // R2 unsigned ge
    {mk(2,0,0,1), 32'hF0,  3'd2, 32'h10,  1'b1},        // R4 masked
    {mk(2,0,0,1), 32'hF0,  3'd2, 32'h0F,  1'b0},
    {mk(2,0,7,1), 32'h5,   3'd2, 32'h5,   1'b0},        // R4 cond none
    {mk(1,0,1,1), 32'h100, 3'd0, 32'h100, 1'b0}         // R12 no access
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable, cpu_rst, step, ext;
  logic [2:0] kind;
  logic [DW-1:0] acc;
  logic [8*N_MP-1:0] mp_ctrl;
  logic [DW*N_MP-1:0] mp_val;
  logic [2*N_WP-1:0] mode;
  logic [N_WP-1:0] sel, brk_en, hit;
  logic [1:0] cnt_en;
  logic [2*CW-1:0] cnt, match, cnt_next;
  logic brk;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wp_chain_unit #(.N_MP(N_MP), .DW(DW), .CW(CW)) u_wp_chain_unit (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cpu_rst_i(cpu_rst),
    .single_step_i(step), .acc_kind_i(kind), .acc_value_i(acc),
    .mp_ctrl_i(mp_ctrl), .mp_value_i(mp_val), .chain_mode_i(mode),
    .cnt_sel_i(sel), .brk_en_i(brk_en), .cnt_en_i(cnt_en), .cnt_i(cnt),
    .cnt_match_i(match), .ext_wp_i(ext), .wp_hit_o(hit), .brk_o(brk),
    .cnt_next_o(cnt_next)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input int wp, input logic [1:0] m);
    mode[2*wp+:2] = m;
  endtask

  task automatic clear();
    enable = 1'b1; cpu_rst = 1'b0; step = 1'b0; ext = 1'b0;
    kind = 3'd0; acc = '0; mp_ctrl = '0; mp_val = '0; mode = '0;
    sel = '0; brk_en = '0; cnt_en = '0; cnt = '0;
    match = {16'h1, 16'h1};
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear();
    @(negedge clk); @(negedge clk);
    chk("R12 reset hits", 64'(hit), 0);
    chk("R12 reset brk", 64'(brk), 0);
    chk("R12 reset cnt", 64'(cnt_next), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mp_ctrl[7:0] = VEC[i][75:68];
      mp_val[31:0] = VEC[i][67:36];
      kind         = VEC[i][35:33];
      acc          = VEC[i][32:1];
      cyc();
      chk($sformatf("R1-table vec %0d", i), 64'(hit), 64'(VEC[i][0]));
    end

    // chaining: mp0 hits fetch 0x100, mp1 does not
    clear();
    mp_ctrl[7:0] = mk(1,0,1,1); mp_val[31:0] = 32'h100;
    mp_ctrl[15:8] = mk(1,0,1,1); mp_val[63:32] = 32'h200;
    kind = 3'd1; acc = 32'h100;
    cyc(); chk("R5 own only", 64'(hit), 64'h1);
    set_mode(1, 2'd1); cyc(); chk("R5 and", 64'(hit), 64'h1);
    set_mode(1, 2'd2); set_mode(2, 2'd2); cyc(); chk("R5 or chain", 64'(hit), 64'h7);
    set_mode(1, 2'd3); cyc(); chk("R5 mode3", 64'(hit), 64'h1);
    set_mode(1, 2'd0); set_mode(2, 2'd0);
    set_mode(0, 2'd1); cyc(); chk("R6 wp0 and self", 64'(hit), 64'h1);
    set_mode(0, 2'd2); mp_val[31:0] = 32'h300; cyc(); chk("R6 wp0 or self", 64'(hit), 64'h0);

    // counter events and external input
    clear();
    kind = 3'd1; cnt = {16'h5, 16'h3}; match = {16'h9, 16'h3};
    cyc(); chk("R7 cnt0 equal", 64'(hit), 64'h100);
    set_mode(8, 2'd1); cyc(); chk("R7 wp8 and wp7", 64'(hit), 64'h0);
    set_mode(8, 2'd0); set_mode(9, 2'd2); cyc(); chk("R7 wp9 or wp8", 64'(hit), 64'h300);
    set_mode(9, 2'd0); ext = 1'b1; cyc(); chk("R7 external", 64'(hit), 64'h500);

    // counting
    clear();
    mp_ctrl[7:0] = mk(1,0,1,1); mp_val[31:0] = 32'h100;
    mp_ctrl[15:8] = mk(1,0,1,1); mp_val[63:32] = 32'h100;
    kind = 3'd1; acc = 32'h100;
    cnt = {16'd20, 16'd10}; match = 32'hFFFF_FFFF;
    cnt_en = 2'b11; sel = 11'b10;
    cyc(); chk("R8 split", 64'(cnt_next), 64'({16'd21, 16'd11}));
    sel = '0; cyc(); chk("R8 both to 0", 64'(cnt_next), 64'({16'd20, 16'd12}));
    cnt_en = 2'b10; cyc(); chk("R8 disabled", 64'(cnt_next), 64'({16'd20, 16'd10}));
    cnt_en = 2'b11; cnt = {16'd7, 16'hFFFF}; match = '0;
    mp_ctrl[15:8] = '0; cyc(); chk("R8 wrap", 64'(cnt_next), 64'({16'd7, 16'h0}));

    // break
    match = 32'hFFFF_FFFF;
    mp_ctrl[15:8] = mk(1,0,1,1);
    brk_en = 11'b10; cyc(); chk("R9 brk", 64'(brk), 1);
    brk_en = 11'b100; cyc(); chk("R9 no brk", 64'(brk), 0);

    // single step
    clear();
    step = 1'b1; kind = 3'd1; cyc(); chk("R10 step fetch", 64'(brk), 1);
    kind = 3'd2; cyc(); chk("R10 step load", 64'(brk), 0);

    // disabled and cpu reset
    clear();
    mp_ctrl[7:0] = mk(1,0,1,1); mp_val[31:0] = 32'h100;
    kind = 3'd1; acc = 32'h100; step = 1'b1; brk_en = '1;
    cnt_en = 2'b11; cnt = {16'd4, 16'd2}; match = {16'd4, 16'd2};
    enable = 1'b0; cyc();
    chk("R11 disabled hits", 64'(hit), 0);
    chk("R11 disabled brk", 64'(brk), 0);
    chk("R11 disabled cnt", 64'(cnt_next), 64'({16'd4, 16'd2}));
    enable = 1'b1; cpu_rst = 1'b1; cyc();
    chk("R11 cpu rst hits", 64'(hit), 0);
    chk("R11 cpu rst brk", 64'(brk), 0);
    cpu_rst = 1'b0; cyc();
    chk("R11 active again", 64'(hit), 64'h301);

    // mid-run reset
    rst_n = 1'b0; #1;
    chk("R12 async reset", 64'(hit), 0);
    @(negedge clk); rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule